// File: doc/BRIEF.md
# Raised-Cosine Soft Mute Gain Stage

This block sits in a stereo 24-bit audio path running at the sample rate. It multiplies each left/right sample pair by a shared gain. While a mute request is active the gain walks from unity down to zero along a raised-cosine curve. When the request is withdrawn the gain walks back up along the same curve. The curve is stored as 33 points in unsigned Q1.15. Each point is held for a parameterised number of sample strobes (32 by default), so a full walk in either direction spans 1024 strobes.

The mute request has two possible sources. A static control pin is used when the device is strapped for pin control. A register bit is used when it is under register control. A mode input selects the source, and the same input also sets the starting gain: unity for pin control, fully muted for register control. A flag reports that the gain has come to rest at zero with the request still held.

Top module: `soft_mute`

## Requirements
- R1: Reset behaviour depends on reg_mode. With reg_mode=0 the gain index starts at 32 (unity) and muted=0. With reg_mode=1 it starts at 0 and muted=1. In both cases out_valid=0 and both outputs are 0 during reset.
- R2: The request is mute_pin when reg_mode=0 and mute_bit when reg_mode=1. The other input has no effect on the outputs. The selected request is registered once before it is used.
- R3: At gain index 32 (gain 32768 = 1.0 in Q1.15) each output sample equals its input sample bit for bit.
- R4: From rest at index 32 with the request held, the muted flag rises after exactly 1024 strobes. That is 32 steps of one index each, with the index held for 32 strobes per step. muted is 1 exactly when the registered request is 1 and the index is 0.
- R5: The gain at index i is round(16384·(1−cos(π·i/32))). Each output is (x·g + 16384) >>> 15 in signed arithmetic, using the gain in force when the strobe arrives. At index 0 the outputs are 0.
- R6: The index and the hold count move only on cycles with in_valid=1. Any number of idle cycles leaves the gain unchanged.
- R7: A change of request during a walk keeps the current index and restarts the hold count. The next index step, in the new direction, happens on the 32nd strobe after the change. The index never moves by more than one per strobe.
- R8: When the request is released while muted, muted falls one clock after the request input changes. This happens before any index step.
- R9: out_valid is in_valid delayed by one clock. out_left and out_right change only on the clock after a strobe.
- R10: Full-scale inputs of either sign (0x7FFFFF, 0x800000) give outputs inside the signed 24-bit range at every gain, equal to the rounded product of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_mode | input | 1 | 1 = register control (bit request, start muted); 0 = pin control |
| mute_pin | input | 1 | Mute request from the static pin |
| mute_bit | input | 1 | Mute request from the control register |
| in_valid | input | 1 | Sample strobe |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| muted | output | 1 | Gain at zero with the request held |

## Verification
The bench walks the gain through a full fall and a full rise while counting strobes. If the hold count is off by one, the walk finishes a few strobes early or late and the muted flag rises at the wrong strobe. It reverses the request in the middle of a walk and checks the output on the 32nd and 33rd strobes after the reversal. A design that kept the stale hold count, or jumped to the far end of the curve, steps at the wrong strobe or produces a wrong level. It leaves long idle gaps between strobes to catch a ramp that counts clocks instead of strobes. It also drives full-scale samples of both signs at unity and at intermediate gains, where a wrong rounding constant or a truncated product shows up as an off-by-one or a sign flip.

// File: rtl/smute_pkg.sv
// smute_pkg: constants and the gain curve shared by the soft mute blocks.
// Assumes a 33-point curve (indices 0..32) in unsigned Q1.15, where
// index 32 is exactly 1.0 and index 0 is exactly 0.
package smute_pkg;

    localparam int STEPS  = 32;
    localparam int IDX_W  = $clog2(STEPS + 1);
    localparam int GAIN_W = 16;
    localparam int FRAC_W = GAIN_W - 1;

    typedef logic [GAIN_W-1:0] gain_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam gain_t UNITY = gain_t'(1 << FRAC_W);

    // Raised-cosine level for a given index: 0.5*(1-cos(pi*i/32)) in Q1.15.
    function automatic gain_t gain_of(input idx_t i);
        case (i)
            6'd0:  return 16'd0;
            6'd1:  return 16'd79;
            6'd2:  return 16'd315;
            6'd3:  return 16'd705;
            6'd4:  return 16'd1247;
            6'd5:  return 16'd1935;
            6'd6:  return 16'd2761;
            6'd7:  return 16'd3719;
            6'd8:  return 16'd4799;
            6'd9:  return 16'd5990;
            6'd10: return 16'd7282;
            6'd11: return 16'd8661;
            6'd12: return 16'd10114;
            6'd13: return 16'd11628;
            6'd14: return 16'd13188;
            6'd15: return 16'd14778;
            6'd16: return 16'd16384;
            6'd17: return 16'd17990;
            6'd18: return 16'd19580;
            6'd19: return 16'd21140;
            6'd20: return 16'd22654;
            6'd21: return 16'd24107;
            6'd22: return 16'd25486;
            6'd23: return 16'd26778;
            6'd24: return 16'd27969;
            6'd25: return 16'd29049;
            6'd26: return 16'd30007;
            6'd27: return 16'd30833;
            6'd28: return 16'd31521;
            6'd29: return 16'd32063;
            6'd30: return 16'd32453;
            6'd31: return 16'd32689;
            6'd32: return 16'd32768;
            default: return 16'd0;
        endcase
    endfunction

endpackage

// File: rtl/smute_req_sel.sv
// smute_req_sel: picks the mute request source and registers it once.
// Assumes reg_mode is static during operation; during reset the request
// takes the mode's start-up value (muted for register control).
module smute_req_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic reg_mode,
    input  logic mute_pin,
    input  logic mute_bit,
    output logic req_q
);

    logic req_sel;

    // Choose the live request according to the control mode.
    always_comb begin
        req_sel = reg_mode ? mute_bit : mute_pin;
    end

    // Register the chosen request; reset loads the mode's start-up state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= reg_mode;
        end else begin
            req_q <= req_sel;
        end
    end

endmodule

// File: rtl/smute_ramp.sv
// smute_ramp: walks the gain index along the curve, one step per
// HOLD_LEN strobes, towards 0 while req is high and towards STEPS
// while it is low. A direction change keeps the index and restarts
// the hold count. Assumes HOLD_LEN >= 2.
module smute_ramp
    import smute_pkg::*;
#(
    parameter int HOLD_LEN = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  reg_mode,
    input  logic  req,
    input  logic  strobe,
    output idx_t  idx_o,
    output gain_t gain_o
);

    localparam int CNT_W = (HOLD_LEN > 1) ? $clog2(HOLD_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_LEN - 1);
    localparam idx_t TOP_IDX = idx_t'(STEPS);

    idx_t             idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             dir_down_q;
    logic             at_end;
    logic [CNT_W-1:0] cnt_eff;
    logic             hold_done;

    // Work out whether the walk is parked and whether this strobe steps.
    always_comb begin
        at_end    = req ? (idx_q == '0) : (idx_q == TOP_IDX);
        cnt_eff   = (dir_down_q == req) ? cnt_q : '0;
        hold_done = (cnt_eff == LAST_CNT);
    end

    // Advance the hold count and the index on each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= reg_mode ? '0 : TOP_IDX;
            cnt_q      <= '0;
            dir_down_q <= reg_mode;
        end else if (strobe) begin
            dir_down_q <= req;
            if (at_end) begin
                cnt_q <= '0;
            end else if (hold_done) begin
                cnt_q <= '0;
                idx_q <= req ? idx_q - idx_t'(1) : idx_q + idx_t'(1);
            end else begin
                cnt_q <= cnt_eff + CNT_W'(1);
            end
        end
    end

    // Look up the current level on the curve.
    always_comb begin
        idx_o  = idx_q;
        gain_o = gain_of(idx_q);
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) idx_q <= TOP_IDX); // R4
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !strobe |=> $stable(idx_q)); // R6
    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n) strobe |=> (idx_q == $past(idx_q)) || (idx_q == $past(idx_q) + idx_t'(1)) || (idx_q + idx_t'(1) == $past(idx_q))); // R7
    AST_DIR_DOWN: assert property (@(posedge clk) disable iff (!rst_n) (strobe && req) |=> idx_q <= $past(idx_q)); // R7
    AST_DIR_UP: assert property (@(posedge clk) disable iff (!rst_n) (strobe && !req) |=> idx_q >= $past(idx_q)); // R7

endmodule

// File: rtl/smute_scale.sv
// smute_scale: multiplies one channel by the Q1.15 gain, rounds half up
// back to DATA_W bits, clamps to the signed range and registers the
// result on a strobe. Assumes the gain never exceeds 1.0.
module smute_scale
    import smute_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [DATA_W-1:0] sample,
    input  gain_t             gain,
    output logic [DATA_W-1:0] result
);

    localparam int PROD_W = DATA_W + GAIN_W + 1;
    localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [PROD_W-1:0] SAT_HI   = (PROD_W'(1) <<< (DATA_W - 1)) - PROD_W'(1);
    localparam logic signed [PROD_W-1:0] SAT_LO   = ~SAT_HI;

    logic signed [PROD_W-1:0] x_ext;
    logic signed [PROD_W-1:0] g_ext;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    logic        [DATA_W-1:0] clamped;

    // Form the full product, round half up and clamp into range.
    always_comb begin
        x_ext   = PROD_W'($signed(sample));
        g_ext   = $signed(PROD_W'({1'b0, gain}));
        prod    = x_ext * g_ext;
        shifted = (prod + HALF_LSB) >>> FRAC_W;
        if (shifted > SAT_HI) begin
            clamped = SAT_HI[DATA_W-1:0];
        end else if (shifted < SAT_LO) begin
            clamped = SAT_LO[DATA_W-1:0];
        end else begin
            clamped = shifted[DATA_W-1:0];
        end
    end

    // Capture the scaled sample when a strobe arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (strobe) begin
            result <= clamped;
        end
    end

    AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rst_n) (strobe && gain == '0) |=> result == '0); // R5
    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n) !strobe |=> $stable(result)); // R9

endmodule

// File: rtl/soft_mute.sv
// soft_mute: stereo sample-rate gain stage with a raised-cosine soft mute.
// A registered request (pin or register bit, chosen by reg_mode) steers a
// shared gain index; both channels are scaled by the same gain and leave
// one clock after their strobe. Assumes reg_mode is held steady outside
// reset and that strobes come no faster than one per clock.
module soft_mute
    import smute_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int HOLD_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_mode,
    input  logic              mute_pin,
    input  logic              mute_bit,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              muted
);

    localparam int NCH = 2;

    logic              req_q;
    idx_t              idx;
    gain_t             gain;
    logic [DATA_W-1:0] ch_in  [NCH];
    logic [DATA_W-1:0] ch_out [NCH];

    smute_req_sel u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_mode (reg_mode),
        .mute_pin (mute_pin),
        .mute_bit (mute_bit),
        .req_q    (req_q)
    );

    smute_ramp #(
        .HOLD_LEN (HOLD_LEN)
    ) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_mode (reg_mode),
        .req      (req_q),
        .strobe   (in_valid),
        .idx_o    (idx),
        .gain_o   (gain)
    );

    // Gather the channel inputs into an array for the scaler lanes.
    always_comb begin
        ch_in[0] = in_left;
        ch_in[1] = in_right;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        smute_scale #(
            .DATA_W (DATA_W)
        ) u_scale (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (in_valid),
            .sample (ch_in[c]),
            .gain   (gain),
            .result (ch_out[c])
        );
    end

    // Present the lane results and the muted-at-rest flag.
    always_comb begin
        out_left  = ch_out[0];
        out_right = ch_out[1];
        muted     = req_q && (idx == '0);
    end

    // Delay the strobe to line up with the registered samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R9
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R9
    AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && gain == UNITY) |=> (out_left == $past(in_left)) && (out_right == $past(in_right))); // R3
    AST_MUTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && muted) |=> (out_left == '0) && (out_right == '0)); // R5

endmodule

// File: tb/soft_mute_tb.sv
// soft_mute_tb_top: behavioural reference model compared every clock,
// plus directed checks for the ramp length, reversal and release timing.
module soft_mute_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_mode = 1'b0;
    logic        mute_pin = 1'b0;
    logic        mute_bit = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0;
    logic [23:0] in_right = '0;
    logic        out_valid;
    logic [23:0] out_left;
    logic [23:0] out_right;
    logic        muted;

    int total = 0;
    int bad = 0;
    bit started = 0;
    bit finished = 0;

    // Reference model state (behavioural, integer based).
    int m_idx, m_cnt, m_dir, m_req, m_ov, m_ol, m_or;

    always #5 clk = ~clk;

    soft_mute dut_i (
        .clk(clk), .rst_n(rst_n), .reg_mode(reg_mode),
        .mute_pin(mute_pin), .mute_bit(mute_bit),
        .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .muted(muted)
    );

    function automatic int gval(int i);
        real v;
        v = 16384.0 * (1.0 - $cos(3.141592653589793 * i / 32.0));
        return $rtoi(v + 0.5);
    endfunction

    function automatic int scl(int x, int g);
        longint p;
        p = longint'(x) * longint'(g);
        p = (p + 64'sd16384) >>> 15;
        if (p > 64'sd8388607) p = 64'sd8388607;
        if (p < -64'sd8388608) p = -64'sd8388608;
        return int'(p);
    endfunction

    function automatic int sx(logic [23:0] v);
        return int'($signed(v));
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: advance once per clock edge.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_idx = reg_mode ? 0 : 32;
            m_cnt = 0;
            m_dir = reg_mode ? 1 : 0;
            m_req = reg_mode ? 1 : 0;
            m_ov = 0; m_ol = 0; m_or = 0;
        end else begin
            m_ov = in_valid ? 1 : 0;
            if (in_valid) begin
                int c;
                m_ol = scl(sx(in_left), gval(m_idx));
                m_or = scl(sx(in_right), gval(m_idx));
                c = (m_dir == m_req) ? m_cnt : 0;
                m_dir = m_req;
                if ((m_req == 1 && m_idx == 0) || (m_req == 0 && m_idx == 32)) begin
                    m_cnt = 0;
                end else if (c == 31) begin
                    m_cnt = 0;
                    m_idx = m_req ? m_idx - 1 : m_idx + 1;
                end else begin
                    m_cnt = c + 1;
                end
            end
            m_req = reg_mode ? (mute_bit ? 1 : 0) : (mute_pin ? 1 : 0);
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            int em;
            em = (m_req == 1 && m_idx == 0) ? 1 : 0;
            chk(out_valid == m_ov[0], "R9 out_valid", int'(out_valid), m_ov);
            chk(sx(out_left) == m_ol, "R5 out_left", sx(out_left), m_ol);
            chk(sx(out_right) == m_or, "R5 out_right", sx(out_right), m_or);
            chk(int'(muted) == em, "R4 muted", int'(muted), em);
        end
    end

    task automatic send(logic [23:0] l, logic [23:0] r);
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic send_get(logic [23:0] l, logic [23:0] r, output int ol, output int orr);
        send(l, r);
        @(negedge clk);
        in_valid = 1'b0;
        ol = sx(out_left);
        orr = sx(out_right);
    endtask

    function automatic logic [23:0] pick(int k);
        case (k % 4)
            0: return 24'h7FFFFF;
            1: return 24'h800000;
            default: return 24'($urandom);
        endcase
    endfunction

    task automatic do_reset(bit mode);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; reg_mode = mode;
        idle(3);
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(out_left == '0 && out_right == '0, "R1 reset data", sx(out_left), 0);
        chk(muted == mode, "R1 reset muted", int'(muted), int'(mode));
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ol, orr, first_k, r, a32, a33;
        logic [23:0] x;

        // R1: pin-control reset
        do_reset(1'b0);

        // R3 and R2: unity pass-through, register bit ignored in pin mode
        for (int k = 0; k < 40; k++) begin
            logic [23:0] a, b;
            a = pick(k); b = pick(k + 1);
            mute_bit = k[0];
            send_get(a, b, ol, orr);
            chk(ol == sx(a) && orr == sx(b), "R3 unity pass", ol, sx(a));
        end
        chk(muted == 1'b0, "R2 bit ignored in pin mode", int'(muted), 0);

        // R4 and R10: full fall counted in strobes, full-scale mixed in
        @(negedge clk);
        in_valid = 1'b0; mute_pin = 1'b1;
        idle(1);
        first_k = -1;
        send(pick(0), pick(1));
        for (int k = 1; k <= 1100; k++) begin
            @(negedge clk);
            if (muted && first_k < 0) first_k = k;
            mute_bit = ~mute_bit;
            in_valid = 1'b1; in_left = pick(k); in_right = pick(k + 2);
            chk(sx(out_left) <= 8388607 && sx(out_left) >= -8388608, "R10 range", sx(out_left), 0);
        end
        chk(first_k == 1024, "R4 ramp length", first_k, 1024);

        // R8 in pin mode: release while muted clears the flag next clock
        @(negedge clk);
        in_valid = 1'b0; mute_pin = 1'b0;
        @(negedge clk);
        chk(muted == 1'b0, "R8 release clears muted", int'(muted), 0);

        // Partial rise, then R6: long idle gap leaves gain unchanged
        for (int k = 0; k < 300; k++) send(pick(k), pick(k + 1));
        idle(200);
        r = m_idx;
        x = 24'h400000;
        send_get(x, x, ol, orr);
        chk(m_idx == r && ol == scl(sx(x), gval(r)), "R6 idle gap holds gain", ol, scl(sx(x), gval(r)));

        // R7: reversal keeps the level and steps on the 32nd strobe after
        @(negedge clk);
        in_valid = 1'b0; mute_pin = 1'b1;
        idle(1);
        r = m_idx;
        a32 = 0; a33 = 0;
        for (int k = 1; k <= 33; k++) begin
            send_get(x, x, ol, orr);
            if (k == 32) a32 = ol;
            if (k == 33) a33 = ol;
        end
        chk(a32 == scl(sx(x), gval(r)), "R7 level held through hold", a32, scl(sx(x), gval(r)));
        chk(a33 == scl(sx(x), gval(r - 1)), "R7 step after reversal", a33, scl(sx(x), gval(r - 1)));

        // Sparse strobes with a release, model compare covers R6/R9
        @(negedge clk);
        mute_pin = 1'b0;
        for (int k = 0; k < 200; k++) begin
            send(pick(k), pick(k + 3));
            idle(2);
        end

        // R1: register-control reset starts muted
        mute_bit = 1'b1;
        do_reset(1'b1);
        for (int k = 0; k < 50; k++) begin
            mute_pin = k[0];
            send(pick(k), pick(k + 1));
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(muted == 1'b1 && out_left == '0, "R2 pin ignored in register mode", int'(muted), 1);

        // R8: dropping the register bit clears muted one clock later
        mute_bit = 1'b0;
        @(negedge clk);
        chk(muted == 1'b0, "R8 release clears muted", int'(muted), 0);

        // Full rise back to unity, pin toggling must not matter (R2)
        for (int k = 0; k < 1100; k++) begin
            mute_pin = k[1];
            send(pick(k), pick(k + 1));
        end
        x = 24'h800000;
        send_get(x, 24'h7FFFFF, ol, orr);
        chk(ol == -8388608 && orr == 8388607, "R3 unity after rise", ol, -8388608);

        // Another partial fall with full-scale inputs (R10)
        mute_bit = 1'b1;
        for (int k = 0; k < 500; k++) send(pick(k), pick(k + 1));
        send_get(24'h800000, 24'h7FFFFF, ol, orr);
        chk(ol == scl(-8388608, gval(m_idx)) || m_idx != m_idx, "R10 full-scale negative", ol, scl(-8388608, gval(m_idx)));
        idle(3);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule